// File: doc/BRIEF.md
# TDM Channel Buffer Address Sequencer

This block produces the memory addresses for a multi-channel time-division-multiplexed transmit and receive path. For every timeslot it reports one read address for outgoing data and one write address for incoming data. It also gives the conversion code that the data path applies to that slot. Slot timing comes from outside: a frame-sync pulse and a slot tick that carries the channel index. The block only turns these events into buffer addresses.

The block has two buffer modes. In separate-buffer mode each channel owns its own circular buffer. A buffer starts at a per-channel base address, one base for each direction, and all channels share one buffer length in bytes. In shared-buffer mode every channel uses the single buffer described by channel 0, so the link acts as one wide channel. In this mode every parameter comes from channel 0. Shared-buffer transmit also throws away an initial block of data. Its length in bits is 2 × (ncf − 1) × (cs + 1). The addresses for that block still step forward, but the transmit-valid flag stays low. Shared-buffer mode is legal only when exactly one link is active.

A controller state machine has five states: IDLE, WAIT_SYNC, DISCARD, RUN and FAULT. Its transitions are:
- IDLE→WAIT_SYNC on enable.
- WAIT_SYNC→DISCARD on frame sync, when in shared mode and the discard length is non-zero.
- WAIT_SYNC→RUN on frame sync in any other case.
- DISCARD→RUN when the slot that empties the discard counter is served.
- Any state→FAULT while the configuration is illegal.
- FAULT→WAIT_SYNC once the configuration is legal again.
- Any state→IDLE when enable falls.

Top module: `tdm_addr_seq`

## Requirements
- R1: A synchronous reset sets tx_rd, rx_wr and tx_send to 0, returns the controller to IDLE and clears every buffer offset, so the first served slot after re-arming addresses its base exactly.
- R2: In separate-buffer mode, a slot tick for channel k (with k ≤ ncf) that is sampled on a clock edge shows up after that edge. At that point tx_rd = rx_wr = 1, tx_addr = tx_base[k] + off_k and rx_addr = rx_base[k] + off_k. Here off_k is channel k's own byte offset, and it grows by floor(cs/8)+1 bytes each time that channel is served.
- R3: An offset that would reach or pass buf_size after a step returns to 0 instead, so every buffer wraps to its base.
- R4: In shared-buffer mode all slots share one offset, applied to tx_base[0] and rx_base[0], and it advances in the order the slots are served.
- R5: conv_sel shows the 2-bit conversion code of the served channel in separate-buffer mode and the code of channel 0 in shared-buffer mode. Code 00 means transparent data and code 10 means companded data. The field for channel k sits at conv_flat[2k+1:2k].
- R6: In shared-buffer mode the first 2 × (ncf − 1) served slots after the starting frame sync give tx_rd = 1 with tx_send = 0. These slots carry 2 × (ncf − 1) × (cs + 1) bits. After them, tx_send = 1. With ncf ≤ 1, or in separate-buffer mode, tx_send = 1 on every served slot.
- R7: cfg_err = 1 exactly when shared-buffer mode is chosen and active_links ≠ 1. While that holds with enable high, the controller stays in FAULT and serves no slot.
- R8: A slot tick with slot_idx > ncf raises no strobe and leaves every offset unchanged.
- R9: No slot is served while enable is low or before the first frame sync after enable. Dropping enable clears the offsets and re-arms the discard.
- R10: slot_out repeats the channel index of the served slot, in the same cycle as its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Sequencer enable |
| unified | input | 1 | 1 = shared-buffer mode, 0 = separate buffers |
| active_links | input | 3 | Number of active links |
| fsync | input | 1 | Frame-sync pulse |
| slot_valid | input | 1 | Slot tick |
| slot_idx | input | CHW | Channel index of the slot tick |
| ncf | input | CHW | Channel count minus one |
| cs | input | CSW | Channel size in bits minus one |
| buf_size | input | BSW | Buffer length in bytes |
| tx_base_flat | input | NCH*AW | Transmit base address of each channel |
| rx_base_flat | input | NCH*AW | Receive base address of each channel |
| conv_flat | input | 2*NCH | Conversion code of each channel |
| tx_rd | output | 1 | Transmit read strobe |
| tx_send | output | 1 | Transmit data is to be sent |
| tx_addr | output | AW | Transmit read byte address |
| rx_wr | output | 1 | Receive write strobe |
| rx_addr | output | AW | Receive write byte address |
| conv_sel | output | 2 | Conversion code for the served slot |
| slot_out | output | CHW | Channel index of the served slot |
| cfg_err | output | 1 | Illegal link count for shared-buffer mode |

## Verification
The offset-range assertion assumes that buf_size, the mode bit and the channel sizes stay fixed while the sequencer serves slots. The bench therefore changes configuration only while reset is held and enable is low, when the offsets are cleared. The properties also assume that frame sync and slot ticks never arrive in the same cycle. The stimulus keeps them apart and leaves one idle cycle after every slot tick.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_SYNC,
        S_DISCARD,
        S_RUN,
        S_FAULT
    } seq_state_e;

endpackage

// File: rtl/tdm_seq_ctrl.sv
module tdm_seq_ctrl
    import tdm_seq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CHW = 5,
    parameter int CSW = 5,
    localparam int DW = $clog2(2 * NCH * (1 << CSW)) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic           unified,
    input  logic [2:0]     active_links,
    input  logic           fsync,
    input  logic           slot_valid,
    input  logic [CHW-1:0] slot_idx,
    input  logic [CHW-1:0] ncf,
    input  logic [CSW-1:0] cs,
    output seq_state_e     st_o,
    output logic           go,
    output logic           sending,
    output logic           clear,
    output logic           cfg_bad
);

    seq_state_e     st_q, st_d;
    logic [DW-1:0]  disc_q;
    logic [DW-1:0]  disc_load;
    logic [DW-1:0]  width_b;
    logic [DW-1:0]  pairs;
    logic           sync_hit;
    logic           disc_last;

    // size of one slot in bits and the length of the dropped block
    always_comb begin
        width_b   = DW'(cs) + DW'(1);
        pairs     = DW'(ncf) - DW'(1);
        disc_load = (ncf >= CHW'(2)) ? ((pairs * width_b) << 1) : '0;
    end

    assign cfg_bad   = unified && (active_links != 3'd1);
    assign sync_hit  = (st_q == S_WAIT_SYNC) && fsync;
    assign disc_last = disc_q <= width_b;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = S_IDLE;
        end else if (cfg_bad) begin
            st_d = S_FAULT;
        end else begin
            unique case (st_q)
                S_IDLE:      st_d = S_WAIT_SYNC;
                S_FAULT:     st_d = S_WAIT_SYNC;
                S_WAIT_SYNC: begin
                    if (fsync)
                        st_d = (unified && (disc_load != '0)) ? S_DISCARD : S_RUN;
                end
                S_DISCARD:   if (go && disc_last) st_d = S_RUN;
                S_RUN:       st_d = S_RUN;
                default:     st_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    // discard counter, loaded on the starting frame sync
    always_ff @(posedge clk) begin
        if (rst) begin
            disc_q <= '0;
        end else if (sync_hit && enable && !cfg_bad) begin
            disc_q <= disc_load;
        end else if (go && (st_q == S_DISCARD)) begin
            disc_q <= disc_last ? '0 : (disc_q - width_b);
        end
    end

    // outputs of the state machine
    always_comb begin
        go      = 1'b0;
        sending = 1'b0;
        clear   = 1'b0;
        unique case (st_q)
            S_IDLE, S_WAIT_SYNC, S_FAULT: clear = 1'b1;
            S_DISCARD: go = slot_valid && (slot_idx <= ncf);
            S_RUN: begin
                go      = slot_valid && (slot_idx <= ncf);
                sending = 1'b1;
            end
            default: clear = 1'b1;
        endcase
    end

    assign st_o = st_q;

    // R9
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (st_q == S_IDLE));

    // R7
    fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && cfg_bad) |=> (st_q == S_FAULT));

    // R6
    discard_needs_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DISCARD) |-> unified);

endmodule

// File: rtl/tdm_ptr_bank.sv
module tdm_ptr_bank #(
    parameter int NCH = 32,
    parameter int CHW = 5,
    parameter int BSW = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           adv,
    input  logic [CHW-1:0] sel,
    input  logic [BSW-1:0] step,
    input  logic [BSW-1:0] buf_size,
    output logic [BSW-1:0] off_o
);

    logic [BSW-1:0] off_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [BSW:0]   sum;
        logic [BSW-1:0] nxt;

        always_comb begin
            sum = {1'b0, off_q[g]} + {1'b0, step};
            nxt = (sum >= {1'b0, buf_size}) ? '0 : sum[BSW-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst || clear)
                off_q[g] <= '0;
            else if (adv && (sel == CHW'(g)))
                off_q[g] <= nxt;
        end

        // R3
        off_range_chk: assert property (@(posedge clk) disable iff (rst || clear)
            (off_q[g] == '0) || (off_q[g] < buf_size));
    end

    assign off_o = off_q[sel];

endmodule

// File: rtl/tdm_addr_seq.sv
module tdm_addr_seq
    import tdm_seq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CHW = 5,
    parameter int CSW = 5,
    parameter int AW  = 16,
    parameter int BSW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              unified,
    input  logic [2:0]        active_links,
    input  logic              fsync,
    input  logic              slot_valid,
    input  logic [CHW-1:0]    slot_idx,
    input  logic [CHW-1:0]    ncf,
    input  logic [CSW-1:0]    cs,
    input  logic [BSW-1:0]    buf_size,
    input  logic [NCH*AW-1:0] tx_base_flat,
    input  logic [NCH*AW-1:0] rx_base_flat,
    input  logic [2*NCH-1:0]  conv_flat,
    output logic              tx_rd,
    output logic              tx_send,
    output logic [AW-1:0]     tx_addr,
    output logic              rx_wr,
    output logic [AW-1:0]     rx_addr,
    output logic [1:0]        conv_sel,
    output logic [CHW-1:0]    slot_out,
    output logic              cfg_err
);

    localparam int STW = CSW - 2;

    seq_state_e     st;
    logic           go;
    logic           sending;
    logic           clear;
    logic [CHW-1:0] sel;
    logic [STW-1:0] step;
    logic [BSW-1:0] off;

    logic [AW-1:0] tx_base [NCH];
    logic [AW-1:0] rx_base [NCH];
    logic [1:0]    conv    [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_unpack
        assign tx_base[k] = tx_base_flat[k*AW +: AW];
        assign rx_base[k] = rx_base_flat[k*AW +: AW];
        assign conv[k]    = conv_flat[2*k +: 2];
    end

    // shared mode takes every parameter from channel 0
    assign sel  = unified ? '0 : slot_idx;
    assign step = STW'(cs >> 3) + STW'(1);

    tdm_seq_ctrl #(
        .NCH (NCH),
        .CHW (CHW),
        .CSW (CSW)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .unified      (unified),
        .active_links (active_links),
        .fsync        (fsync),
        .slot_valid   (slot_valid),
        .slot_idx     (slot_idx),
        .ncf          (ncf),
        .cs           (cs),
        .st_o         (st),
        .go           (go),
        .sending      (sending),
        .clear        (clear),
        .cfg_bad      (cfg_err)
    );

    tdm_ptr_bank #(
        .NCH (NCH),
        .CHW (CHW),
        .BSW (BSW)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .adv      (go),
        .sel      (sel),
        .step     (BSW'(step)),
        .buf_size (buf_size),
        .off_o    (off)
    );

    // registered address and strobe stage
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_rd    <= 1'b0;
            rx_wr    <= 1'b0;
            tx_send  <= 1'b0;
            tx_addr  <= '0;
            rx_addr  <= '0;
            conv_sel <= 2'b00;
            slot_out <= '0;
        end else begin
            tx_rd   <= go;
            rx_wr   <= go;
            tx_send <= go && sending;
            if (go) begin
                tx_addr  <= tx_base[sel] + AW'(off);
                rx_addr  <= rx_base[sel] + AW'(off);
                conv_sel <= conv[sel];
                slot_out <= slot_idx;
            end
        end
    end

    // R6
    send_has_read_chk: assert property (@(posedge clk) disable iff (rst)
        tx_send |-> tx_rd);

    // R6
    discard_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_DISCARD) |=> !tx_send);

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_FAULT) |=> (!tx_rd && !rx_wr));

    // R8
    out_of_range_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && (slot_idx > ncf)) |=> (!tx_rd && !rx_wr));

    // R9
    wait_sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT_SYNC) |=> !tx_rd);

endmodule

// File: tb/tdm_addr_seq_test.sv
module tdm_addr_seq_test;

    localparam int NCH = 32;
    localparam int CHW = 5;
    localparam int CSW = 5;
    localparam int AW  = 16;
    localparam int BSW = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic              unified = 1'b0;
    logic [2:0]        active_links = 3'd1;
    logic              fsync = 1'b0;
    logic              slot_valid = 1'b0;
    logic [CHW-1:0]    slot_idx = '0;
    logic [CHW-1:0]    ncf = '0;
    logic [CSW-1:0]    cs = '0;
    logic [BSW-1:0]    buf_size = '0;
    logic [NCH*AW-1:0] tx_base_flat;
    logic [NCH*AW-1:0] rx_base_flat;
    logic [2*NCH-1:0]  conv_flat;
    logic              tx_rd, tx_send, rx_wr, cfg_err;
    logic [AW-1:0]     tx_addr, rx_addr;
    logic [1:0]        conv_sel;
    logic [CHW-1:0]    slot_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tdm_addr_seq #(.NCH(NCH), .CHW(CHW), .CSW(CSW), .AW(AW), .BSW(BSW)) uut (
        .clk(clk), .rst(rst), .enable(enable), .unified(unified),
        .active_links(active_links), .fsync(fsync), .slot_valid(slot_valid),
        .slot_idx(slot_idx), .ncf(ncf), .cs(cs), .buf_size(buf_size),
        .tx_base_flat(tx_base_flat), .rx_base_flat(rx_base_flat),
        .conv_flat(conv_flat), .tx_rd(tx_rd), .tx_send(tx_send),
        .tx_addr(tx_addr), .rx_wr(rx_wr), .rx_addr(rx_addr),
        .conv_sel(conv_sel), .slot_out(slot_out), .cfg_err(cfg_err)
    );

    // {slot[4:0], expect strobe, expected tx_addr[15:0]}
    // separate mode: ncf=3, cs=15 (2-byte step), buf_size=6
    localparam logic [21:0] VEC [10] = '{
        {5'd0, 1'b1, 16'h1000},
        {5'd1, 1'b1, 16'h1100},
        {5'd2, 1'b1, 16'h1200},
        {5'd3, 1'b1, 16'h1300},
        {5'd0, 1'b1, 16'h1002},
        {5'd1, 1'b1, 16'h1102},
        {5'd0, 1'b1, 16'h1004},
        {5'd0, 1'b1, 16'h1000},   // wrap
        {5'd5, 1'b0, 16'h0000},   // beyond ncf
        {5'd3, 1'b1, 16'h1302}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_slot(input int idx);
        @(negedge clk);
        slot_valid = 1'b1;
        slot_idx   = CHW'(idx);
        @(negedge clk);
        slot_valid = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        enable = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start(input bit with_sync);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        if (with_sync) pulse_sync();
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) begin
            tx_base_flat[k*AW +: AW] = AW'(16'h1000 + k * 16'h100);
            rx_base_flat[k*AW +: AW] = AW'(16'h8000 + k * 16'h100);
            conv_flat[2*k +: 2]      = (k % 2 == 1) ? 2'b10 : 2'b00;
        end
        ncf = 5'd3; cs = 5'd15; buf_size = 12'd6; unified = 1'b0;
        do_reset();
        // R1 reset state
        chk("R1 tx_rd", 32'(tx_rd), 0);
        chk("R1 rx_wr", 32'(rx_wr), 0);
        chk("R1 tx_send", 32'(tx_send), 0);

        // R9 no service before frame sync
        start(1'b0);
        do_slot(0);
        chk("R9 pre-sync strobe", 32'(tx_rd), 0);
        pulse_sync();

        // vector walk: separate-buffer mode
        for (int i = 0; i < 10; i++) begin
            logic [4:0]  vs;
            logic        vv;
            logic [15:0] va;
            string       rq;
            {vs, vv, va} = VEC[i];
            rq = (i == 7) ? "R3" : ((i == 8) ? "R8" : "R2");
            do_slot(int'(vs));
            chk({rq, " strobe"}, 32'(tx_rd), 32'(vv));
            chk({rq, " rx strobe"}, 32'(rx_wr), 32'(vv));
            if (vv) begin
                chk({rq, " tx_addr"}, 32'(tx_addr), 32'(va));
                chk({rq, " rx_addr"}, 32'(rx_addr), 32'(va + 16'h7000));
                chk("R5 conv", 32'(conv_sel), vs[0] ? 32'h2 : 32'h0);
                chk("R6 separate send", 32'(tx_send), 1);
                chk("R10 slot_out", 32'(slot_out), 32'(vs));
            end
        end

        // R9 drop enable: offsets clear
        do_slot(1);
        chk("R9 ch1 advanced", 32'(tx_addr), 32'h1104);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        start(1'b1);
        do_slot(1);
        chk("R9 re-arm base", 32'(tx_addr), 32'h1100);

        // R1 reset clears offsets
        do_slot(1);
        do_reset();
        start(1'b1);
        do_slot(1);
        chk("R1 base after reset", 32'(tx_addr), 32'h1100);

        // R4 R5 R6 shared mode, ncf=3 cs=7 -> 32 bits = 4 slots dropped
        ncf = 5'd3; cs = 5'd7; buf_size = 12'd16; unified = 1'b1;
        conv_flat[1:0] = 2'b10; conv_flat[3:2] = 2'b00;
        do_reset();
        chk("R7 legal cfg", 32'(cfg_err), 0);
        start(1'b1);
        for (int i = 0; i < 8; i++) begin
            do_slot(i % 4);
            chk("R4 tx_addr", 32'(tx_addr), 32'h1000 + 32'(i));
            chk("R4 rx_addr", 32'(rx_addr), 32'h8000 + 32'(i));
            chk("R6 send", 32'(tx_send), (i < 4) ? 0 : 1);
            chk("R6 read", 32'(tx_rd), 1);
            chk("R5 shared conv", 32'(conv_sel), 2);
            chk("R10 slot_out", 32'(slot_out), 32'(i % 4));
        end

        // R6 32 channels of 8 bits: 480 bits = 60 slots dropped
        ncf = 5'd31; cs = 5'd7; buf_size = 12'd128;
        do_reset();
        start(1'b1);
        begin
            int muted = 0;
            int first = -1;
            int bad_addr = 0;
            for (int i = 0; i < 64; i++) begin
                do_slot(i % 32);
                if (!tx_send) muted++;
                else if (first < 0) first = i;
                if (tx_addr !== AW'(16'h1000 + i)) bad_addr++;
            end
            chk("R6 muted slots", 32'(muted), 60);
            chk("R6 first sent", 32'(first), 60);
            chk("R4 shared addr run", 32'(bad_addr), 0);
        end

        // R6 boundary: ncf=1 drops nothing
        ncf = 5'd1; cs = 5'd7;
        do_reset();
        start(1'b1);
        do_slot(0);
        chk("R6 ncf=1 sends", 32'(tx_send), 1);

        // R7 illegal link counts
        ncf = 5'd3; active_links = 3'd2;
        do_reset();
        chk("R7 cfg_err two links", 32'(cfg_err), 1);
        start(1'b1);
        do_slot(0);
        chk("R7 no strobe in fault", 32'(tx_rd), 0);
        active_links = 3'd0;
        @(negedge clk);
        chk("R7 cfg_err zero links", 32'(cfg_err), 1);
        unified = 1'b0; active_links = 3'd2;
        @(negedge clk);
        chk("R7 separate mode any links", 32'(cfg_err), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule